// File: doc/BRIEF.md
# Debug Address Match Unit

This block sits beside the fetch and load/store stages of a small 32-bit RISC core and decides, in the cycle an event is presented, whether a debug exception must be requested. It holds a set of instruction breakpoint registers and a set of data watchpoint registers. Software or a debug agent programs these registers through a simple write port. The fetch PC is compared against every enabled breakpoint. Each data access address and its direction are compared against every armed watchpoint.

Breakpoints and watchpoints raise separate request lines, and each request comes with the lowest matching entry index. A watchpoint hit also withholds the commit permission for the access in the same cycle. The pipeline can therefore cancel the load or store before it changes any state. The exception entry, the pipeline flush and the debugger transport all live outside this block.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every breakpoint and watchpoint entry is disabled. With any PC or access presented, `bp_req` and `wp_req` stay 0 and both index outputs stay 0.
- R2: The breakpoint request `bp_req` is combinational and asserts in the same cycle as the fetch. It asserts when `pc_valid` is 1 and `pc[31:2]` equals bits 31:2 of an enabled breakpoint. `pc[1:0]` is ignored. When `cfg_wp`=0, a write programs a breakpoint, and bit 0 of `cfg_addr` is that breakpoint's enable.
- R3: Writing a breakpoint with `cfg_addr[0]`=0, or a watchpoint with mode 0, clears that entry so that it never matches. Clearing an entry that is already empty leaves every entry unchanged.
- R4: When `cfg_wp`=1, a write programs a watchpoint, and `cfg_mode` sets its mode. The mode encodings are 0 = disabled, 1 = match reads only (`acc_write`=0), 2 = match writes only (`acc_write`=1), and 3 = match both reads and writes.
- R5: A watchpoint matches only when `acc_valid` is 1 and all 32 bits of `acc_addr` equal the programmed byte address. A nearby byte address does not match.
- R6: `acc_commit` equals 1 only when `acc_valid` is 1 and no watchpoint matches in that cycle. A watchpoint hit therefore blocks the access before it takes effect.
- R7: When several entries of one kind match, one request is raised. Its index output (`bp_idx` or `wp_idx`) gives the lowest matching entry.
- R8: A write through the configuration port takes effect from the clock edge that samples `cfg_we`. Entries that were not addressed keep their contents.
- R9: A breakpoint hit and a watchpoint hit in the same cycle raise `bp_req` and `wp_req` together, each with its own index.
- R10: `bp_idx` is 0 whenever `bp_req` is 0, and `wp_idx` is 0 whenever `wp_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Write target: 0 selects a breakpoint, 1 selects a watchpoint |
| cfg_idx | input | 2 | Entry index |
| cfg_addr | input | 32 | Address to program; for a breakpoint, bit 0 is the enable |
| cfg_mode | input | 2 | Watchpoint mode (0 off, 1 read, 2 write, 3 both) |
| pc_valid | input | 1 | Fetch PC is valid |
| pc | input | 32 | Fetch program counter |
| acc_valid | input | 1 | Data access is valid |
| acc_addr | input | 32 | Data access byte address |
| acc_write | input | 1 | Access direction: 1 = store, 0 = load |
| bp_req | output | 1 | Breakpoint exception request |
| bp_idx | output | 2 | Lowest matching breakpoint index |
| wp_req | output | 1 | Watchpoint exception request |
| wp_idx | output | 2 | Lowest matching watchpoint index |
| acc_commit | output | 1 | Access may complete |

## Verification
The match outputs (`bp_req`, `bp_idx`, `wp_req`, `wp_idx`, `acc_commit`) follow the PC and access inputs with no register in between. The bench therefore drives each vector on the falling edge and samples the outputs a quarter period later, before the next rising edge. A configuration write becomes visible only after the rising edge that samples `cfg_we`. The write-timing check samples once before that edge, where the old contents must still apply, and once after it, where the new entry must match.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

    // Watchpoint direction filter; bit 0 arms loads, bit 1 arms stores
    typedef enum logic [1:0] {
        WP_OFF = 2'b00,
        WP_RD  = 2'b01,
        WP_WR  = 2'b10,
        WP_RW  = 2'b11
    } wp_mode_e;

    function automatic logic wp_dir_ok(input wp_mode_e mode, input logic is_write);
        logic ok;
        case (mode)
            WP_RD:   ok = !is_write;
            WP_WR:   ok = is_write;
            WP_RW:   ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/dbg_bp_bank.sv
module dbg_bp_bank #(
    parameter int NUM = 4,
    parameter int AW  = 32,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [AW-1:0]  wr_addr,
    input  logic           pc_valid,
    input  logic [AW-1:0]  pc,
    output logic [NUM-1:0] hit,
    output logic [NUM-1:0] en
);

    typedef struct packed {
        logic [NUM-1:0]           en;
        logic [NUM-1:0][AW-3:0]   tag;
    } bp_state_t;

    bp_state_t st_d, st_q;

    // Byte-lane bits of the PC and bit 1 of the write data carry no meaning here
    logic lsb_unused;
    assign lsb_unused = ^{pc[1:0], wr_addr[1]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en[wr_idx]  = wr_addr[0];
            st_d.tag[wr_idx] = wr_addr[0] ? wr_addr[AW-1:2] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit[g] = pc_valid & st_q.en[g] & (pc[AW-1:2] == st_q.tag[g]);
    end

    assign en = st_q.en;

endmodule

// File: rtl/dbg_wp_bank.sv
module dbg_wp_bank
    import dbg_cmp_pkg::*;
#(
    parameter int NUM = 4,
    parameter int AW  = 32,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [AW-1:0]  wr_addr,
    input  logic [1:0]     wr_mode,
    input  logic           acc_valid,
    input  logic [AW-1:0]  acc_addr,
    input  logic           acc_write,
    output logic [NUM-1:0] hit
);

    typedef struct packed {
        logic [NUM-1:0][1:0]    mode;
        logic [NUM-1:0][AW-1:0] addr;
    } wp_state_t;

    wp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mode[wr_idx] = wr_mode;
            st_d.addr[wr_idx] = (wp_mode_e'(wr_mode) == WP_OFF) ? '0 : wr_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit[g] = acc_valid
                      & (acc_addr == st_q.addr[g])
                      & wp_dir_ok(wp_mode_e'(st_q.mode[g]), acc_write);
    end

endmodule

// File: rtl/dbg_prio_enc.sv
module dbg_prio_enc #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4,
    parameter int AW     = 32,
    localparam int BPW   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
    localparam int WPW   = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
    localparam int CIW   = (BPW > WPW) ? BPW : WPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_wp,
    input  logic [CIW-1:0] cfg_idx,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [1:0]     cfg_mode,
    input  logic           pc_valid,
    input  logic [AW-1:0]  pc,
    input  logic           acc_valid,
    input  logic [AW-1:0]  acc_addr,
    input  logic           acc_write,
    output logic           bp_req,
    output logic [BPW-1:0] bp_idx,
    output logic           wp_req,
    output logic [WPW-1:0] wp_idx,
    output logic           acc_commit
);

    logic [NUM_BP-1:0] bp_hit;
    logic [NUM_BP-1:0] bp_en;
    logic [NUM_WP-1:0] wp_hit;

    dbg_bp_bank #(.NUM(NUM_BP), .AW(AW)) u_bp_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we & ~cfg_wp),
        .wr_idx   (BPW'(cfg_idx)),
        .wr_addr  (cfg_addr),
        .pc_valid (pc_valid),
        .pc       (pc),
        .hit      (bp_hit),
        .en       (bp_en)
    );

    dbg_wp_bank #(.NUM(NUM_WP), .AW(AW)) u_wp_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we & cfg_wp),
        .wr_idx    (WPW'(cfg_idx)),
        .wr_addr   (cfg_addr),
        .wr_mode   (cfg_mode),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .hit       (wp_hit)
    );

    dbg_prio_enc #(.N(NUM_BP)) u_bp_enc (
        .vec (bp_hit),
        .any (bp_req),
        .idx (bp_idx)
    );

    dbg_prio_enc #(.N(NUM_WP)) u_wp_enc (
        .vec (wp_hit),
        .any (wp_req),
        .idx (wp_idx)
    );

    // A matched access is held back in the same cycle it is seen
    assign acc_commit = acc_valid & ~wp_req;

endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk #(
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4,
    parameter int BPW    = 2,
    parameter int WPW    = 2,
    parameter int CIW    = 2,
    parameter int AW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_wp,
    input logic [CIW-1:0]    cfg_idx,
    input logic [AW-1:0]     cfg_addr,
    input logic              pc_valid,
    input logic              acc_valid,
    input logic              bp_req,
    input logic [BPW-1:0]    bp_idx,
    input logic              wp_req,
    input logic [WPW-1:0]    wp_idx,
    input logic              acc_commit,
    input logic [NUM_BP-1:0] bp_hit,
    input logic [NUM_BP-1:0] bp_en,
    input logic [NUM_WP-1:0] wp_hit
);

    AST_BP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> pc_valid);                                            // R2

    AST_WP_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        wp_req |-> acc_valid);                                           // R5

    AST_COMMIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && wp_req) |-> !acc_commit);                          // R6

    AST_COMMIT_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !wp_req) |-> acc_commit);                          // R6

    AST_BP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> (bp_hit[bp_idx] &&
                    ((bp_hit & ((NUM_BP'(1) << bp_idx) - NUM_BP'(1))) == '0))); // R7

    AST_WP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        wp_req |-> (wp_hit[wp_idx] &&
                    ((wp_hit & ((NUM_WP'(1) << wp_idx) - NUM_WP'(1))) == '0))); // R7

    AST_BP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wp && !cfg_addr[0]) |=> !bp_en[$past(cfg_idx)]); // R3

    AST_BP_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_req |-> (bp_idx == '0));                                     // R10

    AST_WP_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_req |-> (wp_idx == '0));                                     // R10

endmodule

bind dbg_match_unit dbg_match_unit_chk #(
    .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .BPW(BPW), .WPW(WPW), .CIW(CIW), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wp     (cfg_wp),
    .cfg_idx    (cfg_idx),
    .cfg_addr   (cfg_addr),
    .pc_valid   (pc_valid),
    .acc_valid  (acc_valid),
    .bp_req     (bp_req),
    .bp_idx     (bp_idx),
    .wp_req     (wp_req),
    .wp_idx     (wp_idx),
    .acc_commit (acc_commit),
    .bp_hit     (bp_hit),
    .bp_en      (bp_en),
    .wp_hit     (wp_hit)
);

// File: tb/dbg_match_unit_bench.sv
module dbg_match_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_wp = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_addr = '0;
    logic [1:0]  cfg_mode = '0;
    logic        pc_valid = 1'b0;
    logic [31:0] pc = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        bp_req, wp_req, acc_commit;
    logic [1:0]  bp_idx, wp_idx;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dbg_match_unit u_dbg_match_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wp(cfg_wp),
        .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_mode(cfg_mode),
        .pc_valid(pc_valid), .pc(pc), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .bp_req(bp_req),
        .bp_idx(bp_idx), .wp_req(wp_req), .wp_idx(wp_idx),
        .acc_commit(acc_commit)
    );

    // Expected pack: {bp_req, bp_idx[1:0], wp_req, wp_idx[1:0], acc_commit}
    typedef struct packed {
        logic        pv;
        logic [31:0] pc;
        logic        av;
        logic [31:0] aa;
        logic        aw;
        logic [6:0]  exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h0000_1000, 1'b0, 32'h0, 1'b0, 7'b1_00_0_00_0}, // R2 exact, R7 bp0 over bp2
        '{1'b1, 32'h0000_1003, 1'b0, 32'h0, 1'b0, 7'b1_00_0_00_0}, // R2 low bits ignored
        '{1'b1, 32'h0000_2000, 1'b0, 32'h0, 1'b0, 7'b1_01_0_00_0}, // R2 bp1
        '{1'b1, 32'h0000_1004, 1'b0, 32'h0, 1'b0, 7'b0_00_0_00_0}, // R2 next word misses
        '{1'b0, 32'h0000_1000, 1'b0, 32'h0, 1'b0, 7'b0_00_0_00_0}, // R2 no fetch
        '{1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b0, 7'b0_00_1_00_0}, // R7 wp0 and wp2 hit
        '{1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b1, 7'b0_00_1_10_0}, // R4 store skips read-only wp0
        '{1'b0, 32'h0, 1'b1, 32'h0000_4001, 1'b1, 7'b0_00_1_01_0}, // R4 write-only wp1
        '{1'b0, 32'h0, 1'b1, 32'h0000_4001, 1'b0, 7'b0_00_0_00_1}, // R4 load skips wp1
        '{1'b0, 32'h0, 1'b1, 32'h0000_4002, 1'b1, 7'b0_00_0_00_1}, // R5 byte compare
        '{1'b1, 32'h0000_2000, 1'b1, 32'h0000_5000, 1'b0, 7'b1_01_1_11_0}, // R9 both
        '{1'b0, 32'h0, 1'b0, 32'h0000_4000, 1'b0, 7'b0_00_0_00_0}  // R6 no access
    };

    function automatic logic [6:0] obs();
        return {bp_req, bp_idx, wp_req, wp_idx, acc_commit};
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        n_chk++;
        if (obs() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, obs(), exp);
        end
    endtask

    task automatic drive(input logic pv, input logic [31:0] p, input logic av,
                         input logic [31:0] a, input logic w);
        @(negedge clk);
        pc_valid = pv; pc = p; acc_valid = av; acc_addr = a; acc_write = w;
        #5;
    endtask

    task automatic prog(input logic wp, input logic [1:0] idx,
                        input logic [31:0] addr, input logic [1:0] mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wp = wp; cfg_idx = idx; cfg_addr = addr; cfg_mode = mode;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset leaves every entry empty; address 0 does not match
        drive(1'b1, 32'h0, 1'b1, 32'h0, 1'b0);
        check("R1", 7'b0_00_0_00_1);
        drive(1'b1, 32'h0, 1'b1, 32'h0, 1'b1);
        check("R1", 7'b0_00_0_00_1);

        prog(1'b0, 2'd0, 32'h0000_1001, 2'd0);
        prog(1'b0, 2'd1, 32'h0000_2001, 2'd0);
        prog(1'b0, 2'd2, 32'h0000_1001, 2'd0);
        prog(1'b1, 2'd0, 32'h0000_4000, 2'd1);
        prog(1'b1, 2'd1, 32'h0000_4001, 2'd2);
        prog(1'b1, 2'd2, 32'h0000_4000, 2'd3);
        prog(1'b1, 2'd3, 32'h0000_5000, 2'd3);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].pv, VEC[i].pc, VEC[i].av, VEC[i].aa, VEC[i].aw);
            check($sformatf("table[%0d]", i), VEC[i].exp);
        end

        // R8: the new bp3 applies only after the sampling edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_wp = 1'b0; cfg_idx = 2'd3; cfg_addr = 32'h0000_3001;
        pc_valid = 1'b1; pc = 32'h0000_3000; acc_valid = 1'b0;
        #5;
        check("R8 before edge", 7'b0_00_0_00_0);
        @(negedge clk);
        cfg_we = 1'b0;
        #5;
        check("R8 after edge", 7'b1_11_0_00_0);

        // R3: clearing bp0 exposes bp2 at the same address
        prog(1'b0, 2'd0, 32'h0000_1000, 2'd0);
        drive(1'b1, 32'h0000_1000, 1'b0, 32'h0, 1'b0);
        check("R3 bp0 cleared", 7'b1_10_0_00_0);
        prog(1'b0, 2'd2, 32'h0000_1000, 2'd0);
        drive(1'b1, 32'h0000_1000, 1'b0, 32'h0, 1'b0);
        check("R3 bp2 cleared", 7'b0_00_0_00_0);
        // R3: clearing an empty entry again changes nothing
        prog(1'b0, 2'd2, 32'h0000_0000, 2'd0);
        drive(1'b1, 32'h0000_0000, 1'b0, 32'h0, 1'b0);
        check("R3 empty clear no match", 7'b0_00_0_00_0);
        drive(1'b1, 32'h0000_2000, 1'b0, 32'h0, 1'b0);
        check("R3 R8 bp1 kept", 7'b1_01_0_00_0);

        // R3/R4: mode 0 disables wp2
        prog(1'b1, 2'd2, 32'h0000_4000, 2'd0);
        drive(1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b0);
        check("R4 wp0 read", 7'b0_00_1_00_0);
        drive(1'b0, 32'h0, 1'b1, 32'h0000_4000, 1'b1);
        check("R3 wp2 disabled", 7'b0_00_0_00_1);
        drive(1'b0, 32'h0, 1'b1, 32'h0000_0000, 1'b1);
        check("R3 cleared wp no match at 0", 7'b0_00_0_00_1);

        // R6/R10: store hits wp3 and is blocked; idle idx with no hit
        drive(1'b0, 32'h0, 1'b1, 32'h0000_5000, 1'b1);
        check("R6 blocked store", 7'b0_00_1_11_0);
        drive(1'b1, 32'h0000_5000, 1'b1, 32'h0000_5001, 1'b1);
        check("R10 idle indices", 7'b0_00_0_00_1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule